// File: doc/BRIEF.md
# Prefix-Opcode Bank-Switch Sequencer

This block watches the opcode-fetch cycles of an 8-bit processor with a 16-bit address bus. It drives a seventeenth address line that picks between two full 64K banks. The processor treats certain undefined opcodes as one-byte prefixes. When the block sees one of them, it uses the prefix's upper bits to look up a short timing pattern. While the following instruction runs, it plays that pattern out one bus cycle at a time. Each 1 bit in the pattern flips the bank line. A target instruction can therefore reach the other bank for only the bus cycles in which it reads or writes its operand. The block never decodes the target instruction.

Each clock edge is one bus cycle. The `sync` input marks an opcode-fetch cycle, and `opcode` carries the byte fetched in that cycle. The pattern table is fixed at build time. It holds two families of entries. One family selects the other bank for a single cycle, for ordinary loads and stores. The other family selects it for three cycles in a row, for read-modify-write targets. Once a pattern is finished, the line returns to bank 0.

Top module: `bank_prefix_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `bankHi` to 0 in the following cycle and abandons any pattern in progress.
- R2: A prefix is recognised only when `sync` is high and `opcode[2:0]` equals 3'b011. An opcode fetch with any other low three bits leaves `bankHi` at 0 when no pattern is running.
- R3: A byte whose low three bits are 3'b011, presented while `sync` is low, starts nothing, and `bankHi` stays 0.
- R4: Let k be `opcode[7:3]` of a recognised prefix, and let W be its 8-bit bank window. In the n-th cycle after the prefix fetch cycle (n = 1..8), `bankHi` equals bit n-1 of W.
- R5: For k from 0 to 15, W has exactly one bit set, at position k mod 8, so the other bank is selected for a single cycle.
- R6: For k from 16 to 31, W has three adjacent bits set, starting at position min(k mod 8, 5), so the other bank is held for three cycles.
- R7: From the ninth cycle after the prefix fetch, `bankHi` is 0 and stays 0 until the next prefix.
- R8: An opcode fetch that is not a prefix, arriving while a pattern runs, does not change the pattern's effect on `bankHi`.
- R9: A prefix that arrives while a pattern runs drops the old pattern. The new window then applies from the next cycle, counted as cycle 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; one edge per bus cycle |
| rst | input | 1 | Synchronous reset, active high |
| sync | input | 1 | High during an opcode-fetch cycle |
| opcode | input | 8 | Byte on the data bus in the current cycle |
| bankHi | output | 1 | Bank select, used as address bit 16 |

## Verification
A prefix is captured at the clock edge that ends its fetch cycle. Its first window bit appears on `bankHi` right after that edge, so the result for cycle n of the window is due n edges after the fetch edge. A reset has its effect one edge later. The bench drives its inputs on the falling edge and updates its reference model in the same cycle order. It compares `bankHi` on the next falling edge, half a cycle after the register could have changed. This keeps every comparison aligned with the cycle in which that window bit is due.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;

  typedef struct packed {
    logic load;
    logic shift;
    logic finish;
  } seqStrobe_t;

  // Bank window for table entry idx: bit i set means the alternate bank is
  // selected in cycle i+1 after the prefix fetch.
  function automatic logic [31:0] windowFor(int idx, int patW, int rmwLen, int singleCount);
    int j;
    int s;
    logic [31:0] w;
    logic [31:0] lim;
    j = idx % patW;
    if (idx < singleCount) begin
      w = 32'd1 << j;
    end else begin
      s = (j > patW - rmwLen) ? (patW - rmwLen) : j;
      w = ((32'd1 << rmwLen) - 32'd1) << s;
    end
    lim = (32'd1 << patW) - 32'd1;
    return w & lim;
  endfunction

  // Toggle pattern: a bit is 1 wherever the window changes level, LSB first.
  function automatic logic [31:0] patternFor(int idx, int patW, int rmwLen, int singleCount);
    logic [31:0] w;
    logic [31:0] lim;
    w = windowFor(idx, patW, rmwLen, singleCount);
    lim = (32'd1 << patW) - 32'd1;
    return (w ^ (w << 1)) & lim;
  endfunction

endpackage

// File: rtl/bank_seq_ctrl.sv
module bank_seq_ctrl
  import bank_seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TAG_W   = 3,
  parameter logic [TAG_W-1:0] TAG_VAL = 3'b011,
  parameter int PAT_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync,
  input  logic [DATA_W-1:0] opcode,
  output seqStrobe_t        strb
);

  localparam int CNT_W = $clog2(PAT_W + 1);

  logic [CNT_W-1:0] cnt;
  logic             isPrefix;

  assign isPrefix = sync && (opcode[TAG_W-1:0] == TAG_VAL);

  always_comb begin
    strb = '0;
    if (isPrefix) begin
      strb.load = 1'b1;
    end else if (cnt > CNT_W'(1)) begin
      strb.shift = 1'b1;
    end else if (cnt == CNT_W'(1)) begin
      strb.finish = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (strb.load) begin
      cnt <= CNT_W'(PAT_W);
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R4: one datapath action per bus cycle at most
  assert_one_action_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.load, strb.shift, strb.finish}));

  // R9: a prefix in the middle of a pattern restarts the full count
  assert_reload_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (strb.load && cnt != '0) |=> (cnt == CNT_W'(PAT_W)));

endmodule

// File: rtl/bank_seq_dp.sv
module bank_seq_dp
  import bank_seq_pkg::*;
#(
  parameter int SEL_W   = 5,
  parameter int PAT_W   = 8,
  parameter int RMW_LEN = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  seqStrobe_t       strb,
  input  logic [SEL_W-1:0] opSel,
  output logic             bankHi
);

  localparam int ENTRIES      = 1 << SEL_W;
  localparam int SINGLE_COUNT = ENTRIES / 2;

  logic [PAT_W-1:0] patTable [ENTRIES];
  logic [PAT_W-1:0] patSel;
  logic [PAT_W-1:0] shiftReg;
  logic             bankQ;

  for (genvar g = 0; g < ENTRIES; g++) begin : gen_pat
    localparam logic [31:0] FULL = patternFor(g, PAT_W, RMW_LEN, SINGLE_COUNT);
    assign patTable[g] = FULL[PAT_W-1:0];
  end

  assign patSel = patTable[opSel];

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      bankQ    <= 1'b0;
    end else if (strb.load) begin
      bankQ    <= patSel[0];
      shiftReg <= patSel >> 1;
    end else if (strb.shift) begin
      bankQ    <= bankQ ^ shiftReg[0];
      shiftReg <= shiftReg >> 1;
    end else if (strb.finish) begin
      bankQ    <= 1'b0;
      shiftReg <= '0;
    end
  end

  assign bankHi = bankQ;

  // R7: once the pattern ends, the resting bank is restored
  assert_rest_after_end_R7: assert property (@(posedge clk) disable iff (rst)
    strb.finish |=> !bankHi);

  // R2: with no pattern running and no prefix, the line stays at bank 0
  assert_idle_bank0_R2: assert property (@(posedge clk) disable iff (rst)
    (!strb.load && !strb.shift) |=> !bankHi);

endmodule

// File: rtl/bank_prefix_seq.sv
module bank_prefix_seq
  import bank_seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TAG_W   = 3,
  parameter int PAT_W   = 8,
  parameter int RMW_LEN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync,
  input  logic [DATA_W-1:0] opcode,
  output logic              bankHi
);

  localparam int SEL_W = DATA_W - TAG_W;

  seqStrobe_t strb;

  bank_seq_ctrl #(
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .TAG_VAL(TAG_W'(3)),
    .PAT_W  (PAT_W)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .sync  (sync),
    .opcode(opcode),
    .strb  (strb)
  );

  bank_seq_dp #(
    .SEL_W  (SEL_W),
    .PAT_W  (PAT_W),
    .RMW_LEN(RMW_LEN)
  ) u_dp (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .opSel (opcode[DATA_W-1:TAG_W]),
    .bankHi(bankHi)
  );

  // R1: reset returns the line to bank 0 on the next cycle
  assert_reset_bank0_R1: assert property (@(posedge clk)
    rst |=> !bankHi);

endmodule

// File: tb/bank_prefix_seq_tb.sv
module bank_prefix_seq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic       bankHi;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int         modelPos = 0;
  logic [7:0] modelWin = 8'h00;

  always #5 clk = ~clk;

  bank_prefix_seq u_dut (
    .clk(clk), .rst(rst), .sync(sync), .opcode(opcode), .bankHi(bankHi)
  );

  function automatic logic [7:0] expWindow(int k);
    int j;
    int s;
    j = k % 8;
    if (k < 16) return 8'(1 << j);
    s = (j > 5) ? 5 : j;
    return 8'(7 << s);
  endfunction

  // one bus cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input logic r, input logic s, input logic [7:0] op, input string tag);
    logic expBank;
    rst = r; sync = s; opcode = op;
    @(posedge clk);
    if (r) begin
      modelPos = 0;
    end else if (s && op[2:0] == 3'b011) begin
      modelWin = expWindow(int'(op[7:3]));
      modelPos = 1;
    end else if (modelPos > 0 && modelPos < 8) begin
      modelPos++;
    end else begin
      modelPos = 0;
    end
    @(negedge clk);
    expBank = (modelPos > 0) ? modelWin[modelPos-1] : 1'b0;
    checks++;
    if (bankHi !== expBank) begin
      failures++;
      $display("FAIL %s: bankHi=%b expected=%b (pos=%0d)", tag, bankHi, expBank, modelPos);
    end
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) cyc(1, 0, 8'h00, "R1 reset");
    // R3: prefix-shaped byte without sync
    for (int i = 0; i < 4; i++) cyc(0, 0, 8'h0B + 8'(i * 8), "R3 no sync");
    // R2: opcode fetches with other low bits
    cyc(0, 1, 8'h0A, "R2 non-prefix");
    cyc(0, 1, 8'h07, "R2 non-prefix");
    cyc(0, 1, 8'hFF, "R2 non-prefix");
    cyc(0, 1, 8'h00, "R2 non-prefix");
    // R4/R5/R6/R7: every table entry, target fetch right after the prefix
    for (int k = 0; k < 32; k++) begin
      cyc(0, 1, 8'((k << 3) | 3), "R4 prefix");
      cyc(0, 1, 8'hEE, (k < 16) ? "R5 single" : "R6 rmw");
      for (int n = 2; n <= 8; n++) cyc(0, 0, 8'h5A, (k < 16) ? "R5 single" : "R6 rmw");
      for (int n = 0; n < 3; n++) cyc(0, 0, 8'h13, "R7 rest");
    end
    // R8: non-prefix fetches every cycle during a three-cycle pattern
    cyc(0, 1, 8'h93, "R8 prefix");
    for (int n = 1; n <= 10; n++) cyc(0, 1, 8'hA9, "R8 fetches");
    // R9: reload mid-pattern, RMW entry 16 then single entry 3
    cyc(0, 1, 8'h83, "R9 first");
    cyc(0, 0, 8'h00, "R9 first");
    cyc(0, 1, 8'h1B, "R9 reload");
    for (int n = 0; n < 10; n++) cyc(0, 0, 8'h00, "R9 after reload");
    // R9: reload while in the alternate bank
    cyc(0, 1, 8'h83, "R9 first");
    cyc(0, 1, 8'h3B, "R9 reload in bank1");
    for (int n = 0; n < 10; n++) cyc(0, 0, 8'h00, "R9 after reload");
    // R1: reset in the middle of a pattern
    cyc(0, 1, 8'h83, "R1 prefix");
    cyc(1, 0, 8'h00, "R1 reset mid");
    for (int n = 0; n < 9; n++) cyc(0, 0, 8'h00, "R1 after reset");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule